// File: doc/BRIEF.md
# GPIO controller with change interrupts

An eight-pin general-purpose I/O bank sitting behind a small register port. Software picks the direction of each pin, drives output levels, reads input levels and chooses which inputs may raise an interrupt. Input pins are synchronised and compared against a reference level. Any difference on an enabled input raises the shared interrupt line. Two capture modes are available. In the transient mode the interrupt simply reflects whether the pin still differs from its reference. In the latched mode the first change is held, together with the level that caused it, until software reads the level register.

Each four-pin group can be handed over to a serial channel as modem handshake pins. Pins 7:4 go to channel A (index 1) and pins 3:0 go to channel B (index 0). Within a group, from the top pin down, the order is ring indicator, carrier detect, terminal-ready output and set-ready input. While a group is handed over, its three inputs feed that channel's modem status and modem interrupt ports, and its terminal-ready pin follows that channel's modem control input. The I/O registers then have no influence on those pins. A self-clearing software reset in the control register returns the whole block to its reset state.

Top module: `gpio_modem_ctrl`

## Requirements
- R1: After reset the direction (address 0), level (address 1), enable (address 2) and control (address 3) registers all read 0, every pin is an input (`pin_oe` = 0) and `irq` is low.
- R2: A direction bit of 1 makes the pin an output with `pin_oe` high, driving the bit last written to the level register. Reading the level register returns the written value for output pins and the synchronised pin level for input pins.
- R3: A change on an input pin whose enable bit is 1 raises `irq` no more than 3 clock edges after the pin changes. A read of the level register returns the new level, clears the interrupt and takes the current level as the new reference.
- R4: In transient mode (control bit 0 = 0), if an enabled input returns to its reference level before any read, `irq` falls again on its own.
- R5: Pins whose enable bit is 0, and pins configured as outputs, never raise `irq`. While a pin is disabled its reference follows the pin, so enabling it later does not report earlier changes.
- R6: In latched mode (control bit 0 = 1), the first change on an enabled input holds `irq` high, even if the pin returns to its reference level. The level register returns the captured level for that pin until it is read, and that read clears the interrupt.
- R7: Writing 1 to control bit 3 resets every register and all pending state within 2 clock edges. Control bit 3 and bits 7:4 always read 0.
- R8: Control bit 1 hands pins 7:4 to channel A and control bit 2 hands pins 3:0 to channel B. A handed-over group drives only its second-lowest pin (terminal ready), which equals `mdm_dtr` of its channel, whatever the direction register holds.
- R9: In a handed-over group, `mdm_stat` for channel c (bits 3c+2..3c, ordered ring, carrier, set-ready) shows the synchronised pin levels. A change in them sets `mdm_irq[c]` only while `mdm_ien[c]` is 1. A pulse on `mdm_ack[c]` clears `mdm_irq[c]`. These pins never raise `irq`.
- R10: For a group in I/O mode, its channel's `mdm_stat` bits read 0, its `mdm_irq` stays low whatever the pins do, and `mdm_dtr` has no effect on its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only a level-register read has side effects) |
| reg_addr | input | 2 | Register address: 0 direction, 1 level, 2 enable, 3 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| irq | output | 1 | OR of the pending enabled pin interrupts |
| mdm_dtr | input | 2 | Per-channel modem control bit for the terminal-ready pin |
| mdm_ien | input | 2 | Per-channel modem status interrupt enable |
| mdm_ack | input | 2 | Per-channel modem interrupt clear pulse |
| mdm_stat | output | 6 | Per-channel {ring, carrier, set-ready} levels |
| mdm_irq | output | 2 | Per-channel modem status interrupt |

## Verification
The hardest case to reach is a latched interrupt whose pin has already returned to its reference level. Only the captured bit then differs from the live pin. The stimulus arms one input, switches on latched mode, toggles the pin away from its reference and back, and waits past the synchroniser between the steps. It then reads the level register twice: the first read must show the captured level and the second the live level. Handing a group to a channel while its inputs are already high is a second awkward case, because no modem interrupt may fire just from entering the mode.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   typedef enum logic [1:0] {
      RA_DIR   = 2'd0,
      RA_LEVEL = 2'd1,
      RA_IEN   = 2'd2,
      RA_CTRL  = 2'd3
   } reg_addr_e;

   // control register bit positions
   localparam int CTL_LATCH  = 0;
   localparam int CTL_MDM_HI = 1;
   localparam int CTL_MDM_LO = 2;
   localparam int CTL_SRST   = 3;

   // pin roles inside a four-pin group in handshake mode
   localparam int NIB_DSR = 0;
   localparam int NIB_DTR = 1;
   localparam int NIB_CD  = 2;
   localparam int NIB_RI  = 3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] nxt;
      if (s == 0) begin : g_first
         assign nxt = d;
      end else begin : g_rest
         assign nxt = stg[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   stg[s] <= '0;
         else if (clr) stg[s] <= '0;
         else          stg[s] <= nxt;
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] armed,
   input  logic         latch_mode,
   input  logic         level_rd,
   output logic [W-1:0] pend,
   output logic [W-1:0] view
);

   logic [W-1:0] ref_q;
   logic [W-1:0] cap_q;
   logic [W-1:0] hold_q;

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic differs;
      assign differs = lvl[i] ^ ref_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ref_q[i]  <= 1'b0;
            cap_q[i]  <= 1'b0;
            hold_q[i] <= 1'b0;
         end else if (clr) begin
            ref_q[i]  <= 1'b0;
            cap_q[i]  <= 1'b0;
            hold_q[i] <= 1'b0;
         end else begin
            if (level_rd || !armed[i])
               ref_q[i] <= lvl[i];
            if (level_rd || !latch_mode || !armed[i]) begin
               hold_q[i] <= 1'b0;
            end else if (!hold_q[i] && differs) begin
               hold_q[i] <= 1'b1;
               cap_q[i]  <= lvl[i];
            end
         end
      end

      assign pend[i] = armed[i] & (latch_mode ? hold_q[i] : differs);
      assign view[i] = (latch_mode && hold_q[i]) ? cap_q[i] : lvl[i];
   end

endmodule

// File: rtl/gpio_nib_mux.sv
module gpio_nib_mux
   import gpio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [3:0] lvl,
   input  logic [3:0] io_oe,
   input  logic [3:0] io_out,
   input  logic       dtr_ctl,
   input  logic       ien,
   input  logic       ack,
   output logic [3:0] oe,
   output logic [3:0] out,
   output logic [2:0] stat,
   output logic       irq
);

   logic [2:0] prev_q;
   logic       en_q;
   logic       irq_q;

   assign stat = en ? {lvl[NIB_RI], lvl[NIB_CD], lvl[NIB_DSR]} : 3'b000;

   always_comb begin
      if (en) begin
         oe           = 4'b0000;
         out          = 4'b0000;
         oe[NIB_DTR]  = 1'b1;
         out[NIB_DTR] = dtr_ctl;
      end else begin
         oe  = io_oe;
         out = io_out;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         en_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else if (clr) begin
         prev_q <= '0;
         en_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         prev_q <= stat;
         en_q   <= en;
         if (!en)
            irq_q <= 1'b0;
         else if (en_q && ien && (stat != prev_q))
            irq_q <= 1'b1;
         else if (ack)
            irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

endmodule

// File: rtl/gpio_modem_ctrl.sv
module gpio_modem_ctrl
   import gpio_pkg::*;
#(
   parameter  int NIBBLES     = 2,
   parameter  int SYNC_STAGES = 2,
   localparam int W           = 4 * NIBBLES,
   localparam int ST          = 3 * NIBBLES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [1:0]         reg_addr,
   input  logic [W-1:0]       reg_wdata,
   output logic [W-1:0]       reg_rdata,
   input  logic [W-1:0]       pin_in,
   output logic [W-1:0]       pin_out,
   output logic [W-1:0]       pin_oe,
   output logic               irq,
   input  logic [NIBBLES-1:0] mdm_dtr,
   input  logic [NIBBLES-1:0] mdm_ien,
   input  logic [NIBBLES-1:0] mdm_ack,
   output logic [ST-1:0]      mdm_stat,
   output logic [NIBBLES-1:0] mdm_irq
);

   if (NIBBLES != 2) begin : g_bad_nibbles
      $error("gpio_modem_ctrl: control layout holds exactly two group bits");
   end

   logic [W-1:0]       dir_q, out_q, ien_q;
   logic               latch_q;
   logic [NIBBLES-1:0] mdm_mode_q;
   logic               srst_q;

   logic wr_dir, wr_level, wr_ien, wr_ctrl, level_rd;
   assign wr_dir   = reg_wr && (reg_addr == RA_DIR);
   assign wr_level = reg_wr && (reg_addr == RA_LEVEL);
   assign wr_ien   = reg_wr && (reg_addr == RA_IEN);
   assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
   assign level_rd = reg_rd && (reg_addr == RA_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= wr_ctrl && reg_wdata[CTL_SRST];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q      <= '0;
         out_q      <= '0;
         ien_q      <= '0;
         latch_q    <= 1'b0;
         mdm_mode_q <= '0;
      end else if (srst_q) begin
         dir_q      <= '0;
         out_q      <= '0;
         ien_q      <= '0;
         latch_q    <= 1'b0;
         mdm_mode_q <= '0;
      end else begin
         if (wr_dir)   dir_q <= reg_wdata;
         if (wr_level) out_q <= reg_wdata;
         if (wr_ien)   ien_q <= reg_wdata;
         if (wr_ctrl) begin
            latch_q <= reg_wdata[CTL_LATCH];
            for (int k = 0; k < NIBBLES; k++)
               mdm_mode_q[k] <= reg_wdata[CTL_MDM_LO - k];
         end
      end
   end

   logic [W-1:0] sync_lvl;

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (srst_q),
      .d     (pin_in),
      .q     (sync_lvl)
   );

   logic [W-1:0] mode_pin;
   logic [W-1:0] armed;
   logic [W-1:0] pend;
   logic [W-1:0] in_view;

   assign armed = ien_q & ~dir_q & ~mode_pin;

   gpio_chg_detect #(.W(W)) u_chg (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (srst_q),
      .lvl        (sync_lvl),
      .armed      (armed),
      .latch_mode (latch_q),
      .level_rd   (level_rd),
      .pend       (pend),
      .view       (in_view)
   );

   assign irq = |pend;

   for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
      localparam int LO = 4 * k;
      logic [3:0] nib_oe, nib_out;

      assign mode_pin[LO+3:LO] = {4{mdm_mode_q[k]}};

      gpio_nib_mux u_mux (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (srst_q),
         .en      (mdm_mode_q[k]),
         .lvl     (sync_lvl[LO+3:LO]),
         .io_oe   (dir_q[LO+3:LO]),
         .io_out  (out_q[LO+3:LO]),
         .dtr_ctl (mdm_dtr[k]),
         .ien     (mdm_ien[k]),
         .ack     (mdm_ack[k]),
         .oe      (nib_oe),
         .out     (nib_out),
         .stat    (mdm_stat[3*k+2:3*k]),
         .irq     (mdm_irq[k])
      );

      assign pin_oe[LO+3:LO]  = nib_oe;
      assign pin_out[LO+3:LO] = nib_out;
   end

   logic [W-1:0] level_view;
   always_comb begin
      for (int i = 0; i < W; i++)
         level_view[i] = mode_pin[i] ? sync_lvl[i]
                       : (dir_q[i] ? out_q[i] : in_view[i]);
   end

   logic [W-1:0] ctrl_view;
   always_comb begin
      ctrl_view            = '0;
      ctrl_view[CTL_LATCH] = latch_q;
      for (int k = 0; k < NIBBLES; k++)
         ctrl_view[CTL_MDM_LO - k] = mdm_mode_q[k];
   end

   always_comb begin
      case (reg_addr)
         RA_DIR:   reg_rdata = dir_q;
         RA_LEVEL: reg_rdata = level_view;
         RA_IEN:   reg_rdata = ien_q;
         default:  reg_rdata = ctrl_view;
      endcase
   end

endmodule

// File: rtl/gpio_modem_ctrl_chk.sv
module gpio_modem_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       reg_rd,
   input logic [1:0] reg_addr,
   input logic [7:0] reg_wdata,
   input logic [7:0] reg_rdata,
   input logic [7:0] pin_out,
   input logic [7:0] pin_oe,
   input logic       irq,
   input logic [1:0] mdm_dtr,
   input logic [1:0] mdm_ien,
   input logic [5:0] mdm_stat,
   input logic [1:0] mdm_irq,
   input logic [7:0] ien_q,
   input logic       latch_q,
   input logic [1:0] mdm_mode_q,
   input logic       srst_q
);

   p_ctrl_rsv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd3) |-> (reg_rdata[7:3] == 5'd0));

   p_srst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3 && reg_wdata[3])
         |=> ##1 (pin_oe == 8'd0 && !irq && mdm_irq == 2'd0));

   p_no_irq_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == 8'd0) |-> !irq);

   p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && irq && !reg_wr && !(reg_rd && reg_addr == 2'd1) && !srst_q)
         |=> irq);

   p_dtr_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mdm_mode_q[1] |-> (pin_oe[7:4] == 4'b0010 && pin_out[5] == mdm_dtr[1]));

   p_dtr_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mdm_mode_q[0] |-> (pin_oe[3:0] == 4'b0010 && pin_out[1] == mdm_dtr[0]));

   p_io_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mdm_mode_q[0] |-> (mdm_stat[2:0] == 3'd0));

   p_io_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mdm_mode_q[1] && $past(!mdm_mode_q[1])) |-> !mdm_irq[1]);

   p_mdm_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdm_irq[1]) |-> $past(mdm_ien[1]));

endmodule

bind gpio_modem_ctrl gpio_modem_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq        (irq),
   .mdm_dtr    (mdm_dtr),
   .mdm_ien    (mdm_ien),
   .mdm_stat   (mdm_stat),
   .mdm_irq    (mdm_irq),
   .ien_q      (ien_q),
   .latch_q    (latch_q),
   .mdm_mode_q (mdm_mode_q),
   .srst_q     (srst_q)
);

// File: tb/gpio_modem_ctrl_test.sv
module gpio_modem_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic [7:0] pin_in = 8'd0;
   logic [7:0] pin_out, pin_oe;
   logic       irq;
   logic [1:0] mdm_dtr = 2'd0;
   logic [1:0] mdm_ien = 2'd0;
   logic [1:0] mdm_ack = 2'd0;
   logic [5:0] mdm_stat;
   logic [1:0] mdm_irq;

   always #5 clk = ~clk;

   gpio_modem_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq),
      .mdm_dtr   (mdm_dtr),
      .mdm_ien   (mdm_ien),
      .mdm_ack   (mdm_ack),
      .mdm_stat  (mdm_stat),
      .mdm_irq   (mdm_irq)
   );

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: compares every register read against the scoreboard
   always @(negedge clk) begin
      #2;
      if (reg_rd) begin
         if (sb_q.size() == 0) begin
            chk("read with empty scoreboard", reg_rdata, 8'hxx);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, reg_rdata, e.exp);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      exp_t e;
      @(negedge clk);
      e.exp = exp; e.tag = tag;
      sb_q.push_back(e);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      rd(2'd0, 8'h00, "R1 dir");
      rd(2'd1, 8'h00, "R1 level");
      rd(2'd2, 8'h00, "R1 ien");
      rd(2'd3, 8'h00, "R1 ctrl");
      step(1);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 pin_oe", pin_oe, 8'h00);

      // R2 outputs
      wr(2'd0, 8'hF0);
      wr(2'd1, 8'hA5);
      step(1);
      chk("R2 pin_oe", pin_oe, 8'hF0);
      chk("R2 pin_out", pin_out & 8'hF0, 8'hA0);
      rd(2'd1, 8'hA0, "R2 level readback");

      // R5 outputs never interrupt
      wr(2'd2, 8'hFF);
      pin_in[7:4] = 4'hF;
      step(4);
      chk("R5 output pins toggled", {7'd0, irq}, 8'h00);
      wr(2'd2, 8'h01);

      // R3 change raises irq, read clears
      pin_in[0] = 1'b1;
      step(3);
      chk("R3 irq after change", {7'd0, irq}, 8'h01);
      rd(2'd1, 8'hA1, "R3 level after change");
      step(1);
      chk("R3 irq after read", {7'd0, irq}, 8'h00);

      // R4 transient auto clear
      pin_in[0] = 1'b0;
      step(3);
      chk("R4 irq on change", {7'd0, irq}, 8'h01);
      pin_in[0] = 1'b1;
      step(3);
      chk("R4 irq after return", {7'd0, irq}, 8'h00);

      // R5 disabled pin, then enabled later
      pin_in[1] = 1'b1;
      step(3);
      chk("R5 disabled pin", {7'd0, irq}, 8'h00);
      wr(2'd2, 8'h03);
      step(2);
      chk("R5 enable after change", {7'd0, irq}, 8'h00);

      // R6 latched capture
      wr(2'd3, 8'h01);
      pin_in[0] = 1'b0;
      step(3);
      chk("R6 irq on change", {7'd0, irq}, 8'h01);
      pin_in[0] = 1'b1;
      step(3);
      chk("R6 irq held after return", {7'd0, irq}, 8'h01);
      rd(2'd1, 8'hA2, "R6 captured level");
      step(1);
      chk("R6 irq after read", {7'd0, irq}, 8'h00);
      rd(2'd1, 8'hA3, "R6 live level");

      // R7 software reset
      wr(2'd3, 8'h09);
      step(2);
      rd(2'd3, 8'h00, "R7 ctrl");
      rd(2'd0, 8'h00, "R7 dir");
      rd(2'd2, 8'h00, "R7 ien");
      step(1);
      chk("R7 pin_oe", pin_oe, 8'h00);
      chk("R7 irq", {7'd0, irq}, 8'h00);
      rd(2'd1, 8'hF3, "R7 level all inputs");

      // R8 handover of pins 7:4 to channel A
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h02);
      mdm_dtr = 2'b10;
      step(1);
      chk("R8 pin_oe", pin_oe, 8'h2F);
      chk("R8 dtr high", {7'd0, pin_out[5]}, 8'h01);
      mdm_dtr = 2'b00;
      step(1);
      chk("R8 dtr low", {7'd0, pin_out[5]}, 8'h00);

      // R9 modem status path
      wr(2'd2, 8'hFF);
      mdm_ien = 2'b11;
      step(3);
      chk("R9 status on entry", {2'b00, mdm_stat}, 8'h38);
      chk("R9 no irq on entry", {6'd0, mdm_irq}, 8'h00);
      pin_in[7] = 1'b0;
      step(4);
      chk("R9 status after ring change", {2'b00, mdm_stat}, 8'h18);
      chk("R9 modem irq", {6'd0, mdm_irq}, 8'h02);
      chk("R9 pin irq isolated", {7'd0, irq}, 8'h00);
      @(negedge clk);
      mdm_ack = 2'b10;
      @(negedge clk);
      mdm_ack = 2'b00;
      step(1);
      chk("R9 ack clears", {6'd0, mdm_irq}, 8'h00);
      mdm_ien = 2'b01;
      pin_in[7] = 1'b1;
      step(4);
      chk("R9 disabled modem irq", {6'd0, mdm_irq}, 8'h00);

      // R10 group B stays in I/O mode
      wr(2'd0, 8'hF0);
      mdm_dtr = 2'b01;
      pin_in[3] = 1'b1;
      step(4);
      chk("R10 status zero", {5'd0, mdm_stat[2:0]}, 8'h00);
      chk("R10 modem irq low", {7'd0, mdm_irq[0]}, 8'h00);
      chk("R10 dtr ignored", {6'd0, pin_oe[1], pin_out[1]}, 8'h00);
      chk("R10 pin irq instead", {7'd0, irq}, 8'h01);

      step(2);
      chk("scoreboard drained", 8'(sb_q.size()), 8'h00);
      done = 1'b1;
      finish_run();
   end

endmodule